// File: doc/BRIEF.md
# I2C Transmit and Receive Byte Queues

This block holds the two byte queues that an I2C controller keeps between its bus protocol engine and the processor. One queue carries bytes towards the bus. The other carries bytes received from the bus. The processor reaches both through one shared data port. A write on that port loads the transmit queue, and a read takes the oldest byte from the receive queue. The protocol engine works on the far side of each queue. It takes bytes to send and deposits bytes it has received.

Each queue reports its fill level, its empty and full state, and a level-following threshold flag compared against a programmable 4-bit level. Each queue has a flush request that clears itself. The receive queue is held empty while the peripheral is disabled. A loadable receive length counter tracks how many bytes of the current transfer remain, and a loaded length of zero stands for 256. Two sticky error flags catch the slave-mode cases where a data bit begins with no room to store a byte or no byte to send. Every flag reaches an interrupt line only through its own enable bit.

Top module: `i2cq_buffers`

## Requirements
- R1: Each queue is first in, first out. A `cpu_wr` loads `cpu_wdata` into the transmit queue, whose oldest byte is always visible on `bus_tx_data` and is removed by `bus_tx_pop`. A `bus_rx_push` loads `bus_rx_data` into the receive queue, whose oldest byte is always visible on `cpu_rdata` and is removed by `cpu_rd`. Every change appears one clock after the strobe.
- R2: After reset both counts are 0 and both empty outputs are 1. A count always lies between 0 and DEPTH. Empty is 1 exactly when the count is 0, and full is 1 exactly when the count is DEPTH.
- R3: A load into a full queue is dropped, and a removal from an empty queue is dropped. Neither one changes the count, the stored bytes or the order of later bytes.
- R4: `rx_thr_flag` is 1 whenever `rx_count` is greater than or equal to `rx_thresh`. It falls on its own once the count drops below that level.
- R5: `tx_thr_flag` is 1 whenever `tx_count` is less than or equal to `tx_thresh`. It falls on its own once the count rises above that level.
- R6: A pulse on a flush request sets that queue's flush-busy output on the next clock. On the following clock the queue is emptied and flush-busy returns to 0 by itself. The flush overrides any load or removal in that same cycle.
- R7: While `enable` is 0 the receive queue is emptied and stays empty, and incoming bytes are dropped. The transmit queue is not affected.
- R8: `len_load` sets `bytes_left` to `len_value`, or to 256 when `len_value` is 0. Each `bus_rx_push` then lowers it by one until it reaches 0. `len_done` is 1 exactly when `bytes_left` is 0.
- R9: `rx_ovf_flag` is set when `slv_rx_first_bit` is pulsed while the receive queue is full and `rx_shift_full` is 1.
- R10: `tx_unf_flag` is set when `slv_tx_first_bit` is pulsed while the transmit queue is empty and `master_nacked` is 0.
- R11: Both error flags hold their value until cleared through `err_clr`, where bit 0 clears the overflow flag and bit 1 clears the underflow flag. A set in the same cycle as a clear wins.
- R12: Each bit of `irq` equals its flag AND the matching bit of `irq_en`. Bit 0 is the receive threshold, bit 1 the transmit threshold, bit 2 overflow and bit 3 underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable; when 0 the receive queue is held empty |
| cpu_wr | input | 1 | Processor write strobe on the data port |
| cpu_wdata | input | 8 | Byte written by the processor |
| cpu_rd | input | 1 | Processor read strobe on the data port |
| cpu_rdata | output | 8 | Oldest byte in the receive queue |
| bus_rx_push | input | 1 | Engine delivers a received byte |
| bus_rx_data | input | 8 | Received byte |
| bus_tx_pop | input | 1 | Engine takes the next byte to send |
| bus_tx_data | output | 8 | Oldest byte in the transmit queue |
| rx_flush_wr | input | 1 | Write-1 flush request for the receive queue |
| tx_flush_wr | input | 1 | Write-1 flush request for the transmit queue |
| rx_flush_busy | output | 1 | Receive flush bit, self-clearing |
| tx_flush_busy | output | 1 | Transmit flush bit, self-clearing |
| rx_thresh | input | 4 | Receive threshold level |
| tx_thresh | input | 4 | Transmit threshold level |
| rx_count | output | CNT_W | Receive fill count |
| tx_count | output | CNT_W | Transmit fill count |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_thr_flag | output | 1 | Receive count at or above threshold |
| tx_thr_flag | output | 1 | Transmit count at or below threshold |
| len_load | input | 1 | Load the receive length counter |
| len_value | input | 8 | Transfer length; 0 means 256 |
| bytes_left | output | 9 | Bytes still expected in the transfer |
| len_done | output | 1 | Length counter at zero |
| slv_rx_first_bit | input | 1 | First data bit of a slave-receive byte |
| rx_shift_full | input | 1 | Engine receive shift register holds a byte |
| slv_tx_first_bit | input | 1 | First data bit of a slave-transmit byte |
| master_nacked | input | 1 | Master has already answered NACK |
| err_clr | input | 2 | Write-1 clear: bit 0 overflow, bit 1 underflow |
| rx_ovf_flag | output | 1 | Sticky receive overflow |
| tx_unf_flag | output | 1 | Sticky transmit underflow |
| irq_en | input | 4 | Interrupt enables |
| irq | output | 4 | Gated interrupt requests |

## Verification
The bench goes after the edges of each queue. It loads a full queue and removes from an empty one, then checks that later bytes still come out in order. A design with a pointer that moves on a dropped access would return the wrong byte or a stale one. The threshold tests step each count across its programmed level in both directions. A latched flag would stay high after the count moves back, and a comparison off by one would switch at the wrong count. The flush and disable tests check that the flush bit is gone a cycle later and that transmit data survives a disable. The length counter is taken through the 256 case and held at zero, where a plain 8-bit load would finish at once and an unguarded decrement would wrap to 511. The error flags are driven with each enabling condition missing in turn, and then with a set and a clear in the same cycle.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

  localparam int unsigned IRQ_N = 4;

  // bit positions of the interrupt vector
  typedef enum logic [1:0] {
    IRQ_RXTH = 2'd0,
    IRQ_TXTH = 2'd1,
    IRQ_OVF  = 2'd2,
    IRQ_UNF  = 2'd3
  } irq_idx_e;

  typedef struct packed {
    logic unf;
    logic ovf;
    logic txth;
    logic rxth;
  } irq_vec_t;

endpackage

// File: rtl/i2cq_byte_fifo.sv
module i2cq_byte_fifo #(
  parameter  int unsigned DW    = 8,
  parameter  int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [DW-1:0]    din,
  input  logic             pop,
  output logic [DW-1:0]    dout,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + PTR_W'(1);
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign push_ok = push && !full && !clear;
  assign pop_ok  = pop && !empty && !clear;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clear) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wr_d = ptr_inc(wr_q);
      if (pop_ok)  rd_d = ptr_inc(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + CNT_W'(1);
        2'b01:   cnt_d = cnt_q - CNT_W'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // storage carries no reset; only the write enable gates it
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign count = cnt_q;

endmodule

// File: rtl/i2cq_len_counter.sv
module i2cq_len_counter #(
  parameter  int unsigned LEN_W  = 8,
  localparam int unsigned LEFT_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LEN_W-1:0]  value,
  input  logic              tick,
  output logic [LEFT_W-1:0] left,
  output logic              done
);

  logic [LEFT_W-1:0] left_q, left_d;
  logic              zero;

  assign zero = (left_q == '0);

  always_comb begin
    left_d = left_q;
    if (load) begin
      // a zero length stands for the largest transfer
      if (value == '0) left_d = LEFT_W'(1) << LEN_W;
      else             left_d = {1'b0, value};
    end else if (tick && !zero) begin
      left_d = left_q - LEFT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign left = left_q;
  assign done = zero;

endmodule

// File: rtl/i2cq_flag_unit.sv
module i2cq_flag_unit
  import i2cq_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned TH_W  = 4,
  localparam int unsigned CMP_W = (CNT_W > TH_W) ? CNT_W : TH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [TH_W-1:0]  rx_thresh,
  input  logic [TH_W-1:0]  tx_thresh,
  input  logic             rx_full,
  input  logic             tx_empty,
  input  logic             slv_rx_first_bit,
  input  logic             rx_shift_full,
  input  logic             slv_tx_first_bit,
  input  logic             master_nacked,
  input  logic [1:0]       err_clr,
  input  logic [IRQ_N-1:0] irq_en,
  output logic             rx_thr_flag,
  output logic             tx_thr_flag,
  output logic             rx_ovf_flag,
  output logic             tx_unf_flag,
  output logic [IRQ_N-1:0] irq
);

  logic [CMP_W-1:0] rx_cnt_x, tx_cnt_x, rx_th_x, tx_th_x;
  logic             ovf_q, ovf_d, unf_q, unf_d;
  logic             ovf_set, unf_set;
  irq_vec_t         flags;

  assign rx_cnt_x = CMP_W'(rx_count);
  assign tx_cnt_x = CMP_W'(tx_count);
  assign rx_th_x  = CMP_W'(rx_thresh);
  assign tx_th_x  = CMP_W'(tx_thresh);

  // level flags follow the counts directly, no latching
  assign rx_thr_flag = (rx_cnt_x >= rx_th_x);
  assign tx_thr_flag = (tx_cnt_x <= tx_th_x);

  assign ovf_set = slv_rx_first_bit && rx_full && rx_shift_full;
  assign unf_set = slv_tx_first_bit && tx_empty && !master_nacked;

  always_comb begin
    ovf_d = ovf_q;
    unf_d = unf_q;
    if (err_clr[0]) ovf_d = 1'b0;
    if (err_clr[1]) unf_d = 1'b0;
    if (ovf_set)    ovf_d = 1'b1;
    if (unf_set)    unf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign rx_ovf_flag = ovf_q;
  assign tx_unf_flag = unf_q;

  assign flags.rxth = rx_thr_flag;
  assign flags.txth = tx_thr_flag;
  assign flags.ovf  = ovf_q;
  assign flags.unf  = unf_q;

  for (genvar i = 0; i < IRQ_N; i++) begin : g_irq
    assign irq[i] = flags[i] & irq_en[i];
  end

endmodule

// File: rtl/i2cq_buffers.sv
module i2cq_buffers
  import i2cq_pkg::*;
#(
  parameter  int unsigned DEPTH = 8,
  parameter  int unsigned TH_W  = 4,
  parameter  int unsigned LEN_W = 8,
  localparam int unsigned DW    = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cpu_wr,
  input  logic [DW-1:0]    cpu_wdata,
  input  logic             cpu_rd,
  output logic [DW-1:0]    cpu_rdata,
  input  logic             bus_rx_push,
  input  logic [DW-1:0]    bus_rx_data,
  input  logic             bus_tx_pop,
  output logic [DW-1:0]    bus_tx_data,
  input  logic             rx_flush_wr,
  input  logic             tx_flush_wr,
  output logic             rx_flush_busy,
  output logic             tx_flush_busy,
  input  logic [TH_W-1:0]  rx_thresh,
  input  logic [TH_W-1:0]  tx_thresh,
  output logic [CNT_W-1:0] rx_count,
  output logic [CNT_W-1:0] tx_count,
  output logic             rx_empty,
  output logic             rx_full,
  output logic             tx_empty,
  output logic             tx_full,
  output logic             rx_thr_flag,
  output logic             tx_thr_flag,
  input  logic             len_load,
  input  logic [LEN_W-1:0] len_value,
  output logic [LEN_W:0]   bytes_left,
  output logic             len_done,
  input  logic             slv_rx_first_bit,
  input  logic             rx_shift_full,
  input  logic             slv_tx_first_bit,
  input  logic             master_nacked,
  input  logic [1:0]       err_clr,
  output logic             rx_ovf_flag,
  output logic             tx_unf_flag,
  input  logic [IRQ_N-1:0] irq_en,
  output logic [IRQ_N-1:0] irq
);

  logic rx_fl_q, rx_fl_d, tx_fl_q, tx_fl_d;
  logic rx_clear, tx_clear;

  // flush bits: set by a write, consumed on the next edge
  always_comb begin
    rx_fl_d = rx_flush_wr;
    tx_fl_d = tx_flush_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_fl_q <= 1'b0;
      tx_fl_q <= 1'b0;
    end else begin
      rx_fl_q <= rx_fl_d;
      tx_fl_q <= tx_fl_d;
    end
  end

  assign rx_clear      = rx_fl_q | ~enable;
  assign tx_clear      = tx_fl_q;
  assign rx_flush_busy = rx_fl_q;
  assign tx_flush_busy = tx_fl_q;

  i2cq_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (tx_clear),
    .push  (cpu_wr),
    .din   (cpu_wdata),
    .pop   (bus_tx_pop),
    .dout  (bus_tx_data),
    .count (tx_count),
    .empty (tx_empty),
    .full  (tx_full)
  );

  i2cq_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (rx_clear),
    .push  (bus_rx_push),
    .din   (bus_rx_data),
    .pop   (cpu_rd),
    .dout  (cpu_rdata),
    .count (rx_count),
    .empty (rx_empty),
    .full  (rx_full)
  );

  i2cq_len_counter #(.LEN_W(LEN_W)) u_len (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (len_load),
    .value (len_value),
    .tick  (bus_rx_push),
    .left  (bytes_left),
    .done  (len_done)
  );

  i2cq_flag_unit #(.CNT_W(CNT_W), .TH_W(TH_W)) u_flags (
    .clk              (clk),
    .rst_n            (rst_n),
    .rx_count         (rx_count),
    .tx_count         (tx_count),
    .rx_thresh        (rx_thresh),
    .tx_thresh        (tx_thresh),
    .rx_full          (rx_full),
    .tx_empty         (tx_empty),
    .slv_rx_first_bit (slv_rx_first_bit),
    .rx_shift_full    (rx_shift_full),
    .slv_tx_first_bit (slv_tx_first_bit),
    .master_nacked    (master_nacked),
    .err_clr          (err_clr),
    .irq_en           (irq_en),
    .rx_thr_flag      (rx_thr_flag),
    .tx_thr_flag      (tx_thr_flag),
    .rx_ovf_flag      (rx_ovf_flag),
    .tx_unf_flag      (tx_unf_flag),
    .irq              (irq)
  );

endmodule

// File: rtl/i2cq_buffers_chk.sv
module i2cq_buffers_chk #(
  parameter  int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             cpu_wr,
  input logic             cpu_rd,
  input logic             bus_rx_push,
  input logic             bus_tx_pop,
  input logic             rx_flush_wr,
  input logic             rx_flush_busy,
  input logic             tx_flush_busy,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] tx_count,
  input logic             rx_empty,
  input logic             rx_full,
  input logic             tx_empty,
  input logic             tx_full,
  input logic             len_load,
  input logic [7:0]       len_value,
  input logic [8:0]       bytes_left,
  input logic             slv_rx_first_bit,
  input logic             rx_shift_full,
  input logic             slv_tx_first_bit,
  input logic             master_nacked,
  input logic             rx_ovf_flag,
  input logic             tx_unf_flag,
  input logic [3:0]       irq_en,
  input logic [3:0]       irq
);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count <= CNT_W'(DEPTH)) && (tx_count <= CNT_W'(DEPTH)));

  assert_not_full_and_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_full && rx_empty) && !(tx_full && tx_empty));

  assert_tx_load_counts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !tx_full && !bus_tx_pop && !tx_flush_busy)
    |=> (tx_count == $past(tx_count) + CNT_W'(1)));

  assert_full_push_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && bus_rx_push && !cpu_rd && !rx_flush_busy && enable)
    |=> (rx_count == CNT_W'(DEPTH)));

  assert_empty_pop_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && bus_tx_pop && !cpu_wr) |=> tx_empty);

  assert_flush_selfclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flush_busy && !rx_flush_wr) |=> !rx_flush_busy);

  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush_busy |=> (rx_count == '0));

  assert_disable_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> rx_empty);

  assert_len_zero_is_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (len_load && len_value == 8'd0) |=> (bytes_left == 9'd256));

  assert_ovf_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_rx_first_bit && rx_full && rx_shift_full) |=> rx_ovf_flag);

  assert_unf_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_tx_first_bit && tx_empty && !master_nacked) |=> tx_unf_flag);

  assert_irq_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~irq_en) == 4'b0000);

endmodule

bind i2cq_buffers i2cq_buffers_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_i2cq_buffers.sv
module tb_i2cq_buffers;

  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk;
  logic             rst_n;
  logic             enable;
  logic             cpu_wr;
  logic [7:0]       cpu_wdata;
  logic             cpu_rd;
  logic [7:0]       cpu_rdata;
  logic             bus_rx_push;
  logic [7:0]       bus_rx_data;
  logic             bus_tx_pop;
  logic [7:0]       bus_tx_data;
  logic             rx_flush_wr, tx_flush_wr;
  logic             rx_flush_busy, tx_flush_busy;
  logic [3:0]       rx_thresh, tx_thresh;
  logic [CNT_W-1:0] rx_count, tx_count;
  logic             rx_empty, rx_full, tx_empty, tx_full;
  logic             rx_thr_flag, tx_thr_flag;
  logic             len_load;
  logic [7:0]       len_value;
  logic [8:0]       bytes_left;
  logic             len_done;
  logic             slv_rx_first_bit, rx_shift_full, slv_tx_first_bit, master_nacked;
  logic [1:0]       err_clr;
  logic             rx_ovf_flag, tx_unf_flag;
  logic [3:0]       irq_en, irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  i2cq_buffers #(.DEPTH(DEPTH)) dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cpu_write(input logic [7:0] b);
    cpu_wr = 1'b1; cpu_wdata = b; tick(); cpu_wr = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    bus_rx_push = 1'b1; bus_rx_data = b; tick(); bus_rx_push = 1'b0;
  endtask

  task automatic cpu_read();
    cpu_rd = 1'b1; tick(); cpu_rd = 1'b0;
  endtask

  task automatic tx_pop();
    bus_tx_pop = 1'b1; tick(); bus_tx_pop = 1'b0;
  endtask

  task automatic flush_both();
    rx_flush_wr = 1'b1; tx_flush_wr = 1'b1; tick();
    rx_flush_wr = 1'b0; tx_flush_wr = 1'b0; tick();
  endtask

  task automatic t_reset();
    chk("R2 rx_count reset", rx_count, 0);
    chk("R2 tx_count reset", tx_count, 0);
    chk("R2 rx_empty reset", rx_empty, 1);
    chk("R2 tx_empty reset", tx_empty, 1);
    chk("R11 ovf reset", rx_ovf_flag, 0);
    chk("R12 irq masked", irq, 0);
  endtask

  task automatic t_order();
    cpu_write(8'hA1); cpu_write(8'hB2); cpu_write(8'hC3);
    chk("R1 tx count 3", tx_count, 3);
    chk("R1 tx head A1", bus_tx_data, 8'hA1);
    tx_pop();
    chk("R1 tx head B2", bus_tx_data, 8'hB2);
    tx_pop();
    chk("R1 tx head C3", bus_tx_data, 8'hC3);
    tx_pop();
    chk("R2 tx empty after drain", tx_empty, 1);
    rx_push(8'h11); rx_push(8'h22);
    chk("R1 rx count 2", rx_count, 2);
    chk("R1 rx head 11", cpu_rdata, 8'h11);
    cpu_read();
    chk("R1 rx head 22", cpu_rdata, 8'h22);
    cpu_read();
    chk("R2 rx empty after drain", rx_empty, 1);
  endtask

  task automatic t_bounds();
    for (int i = 0; i < DEPTH; i++) cpu_write(8'h40 + 8'(i));
    chk("R2 tx full", tx_full, 1);
    chk("R2 tx count DEPTH", tx_count, DEPTH);
    cpu_write(8'hEE);
    chk("R3 full write dropped", tx_count, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R3 tx order kept", bus_tx_data, 8'h40 + i);
      tx_pop();
    end
    tx_pop();
    chk("R3 empty pop dropped", tx_count, 0);
    cpu_write(8'h55);
    chk("R3 tx after empty pop", bus_tx_data, 8'h55);
    tx_pop();
    cpu_read();
    chk("R3 empty read dropped", rx_count, 0);
    rx_push(8'h66);
    chk("R3 rx after empty read", cpu_rdata, 8'h66);
    cpu_read();
  endtask

  task automatic t_thresh();
    rx_thresh = 4'd3; tx_thresh = 4'd2; irq_en = 4'b0011;
    tick();
    rx_push(8'h01); rx_push(8'h02);
    chk("R4 rx below level", rx_thr_flag, 0);
    rx_push(8'h03);
    chk("R4 rx at level", rx_thr_flag, 1);
    chk("R12 irq rx thr", irq[0], 1);
    cpu_read();
    chk("R4 rx self clear", rx_thr_flag, 0);
    chk("R12 irq rx thr off", irq[0], 0);
    chk("R5 tx empty at or below", tx_thr_flag, 1);
    cpu_write(8'h01); cpu_write(8'h02); cpu_write(8'h03);
    chk("R5 tx above level", tx_thr_flag, 0);
    tx_pop();
    chk("R5 tx back at level", tx_thr_flag, 1);
    irq_en = 4'b0000;
    tick();
    chk("R12 irq tx thr masked", irq[1], 0);
    flush_both();
    rx_thresh = 4'd0; tx_thresh = 4'd0;
  endtask

  task automatic t_flush();
    cpu_write(8'h77); cpu_write(8'h78);
    tx_flush_wr = 1'b1; tick(); tx_flush_wr = 1'b0;
    chk("R6 flush bit set", tx_flush_busy, 1);
    chk("R6 count kept first", tx_count, 2);
    tick();
    chk("R6 flush bit self clear", tx_flush_busy, 0);
    chk("R6 tx emptied", tx_count, 0);
    rx_push(8'h99);
    rx_flush_wr = 1'b1; tick(); rx_flush_wr = 1'b0;
    bus_rx_push = 1'b1; bus_rx_data = 8'hAA; tick(); bus_rx_push = 1'b0;
    chk("R6 flush beats push", rx_count, 0);
  endtask

  task automatic t_enable();
    rx_push(8'h01); rx_push(8'h02); cpu_write(8'h33);
    enable = 1'b0; tick();
    chk("R7 rx emptied", rx_count, 0);
    rx_push(8'h05);
    chk("R7 push dropped while off", rx_count, 0);
    chk("R7 tx untouched", tx_count, 1);
    chk("R7 tx data kept", bus_tx_data, 8'h33);
    enable = 1'b1; tick();
    flush_both();
  endtask

  task automatic t_len();
    len_load = 1'b1; len_value = 8'd5; tick(); len_load = 1'b0;
    chk("R8 load 5", bytes_left, 5);
    chk("R8 not done", len_done, 0);
    for (int i = 0; i < 5; i++) rx_push(8'(i));
    chk("R8 counted down", bytes_left, 0);
    chk("R8 done", len_done, 1);
    flush_both();
    len_load = 1'b1; len_value = 8'd0; tick(); len_load = 1'b0;
    chk("R8 zero means 256", bytes_left, 256);
    for (int i = 0; i < 255; i++) rx_push(8'(i));
    chk("R8 one left", bytes_left, 1);
    rx_push(8'hFF);
    chk("R8 256 done", len_done, 1);
    rx_push(8'hFE);
    chk("R8 holds at zero", bytes_left, 0);
    flush_both();
  endtask

  task automatic t_errors();
    irq_en = 4'b1100;
    for (int i = 0; i < DEPTH; i++) rx_push(8'(i));
    slv_rx_first_bit = 1'b1; rx_shift_full = 1'b0; tick(); slv_rx_first_bit = 1'b0;
    chk("R9 no ovf without shift full", rx_ovf_flag, 0);
    slv_rx_first_bit = 1'b1; rx_shift_full = 1'b1; tick(); slv_rx_first_bit = 1'b0;
    chk("R9 ovf set", rx_ovf_flag, 1);
    chk("R12 irq ovf", irq[2], 1);
    tick();
    chk("R11 ovf sticky", rx_ovf_flag, 1);
    err_clr = 2'b01; tick(); err_clr = 2'b00;
    chk("R11 ovf cleared", rx_ovf_flag, 0);
    cpu_read();
    slv_rx_first_bit = 1'b1; tick(); slv_rx_first_bit = 1'b0;
    chk("R9 no ovf when not full", rx_ovf_flag, 0);
    rx_shift_full = 1'b0;
    slv_tx_first_bit = 1'b1; master_nacked = 1'b1; tick(); slv_tx_first_bit = 1'b0;
    chk("R10 no unf after nack", tx_unf_flag, 0);
    master_nacked = 1'b0;
    slv_tx_first_bit = 1'b1; tick(); slv_tx_first_bit = 1'b0;
    chk("R10 unf set", tx_unf_flag, 1);
    chk("R12 irq unf", irq[3], 1);
    slv_tx_first_bit = 1'b1; err_clr = 2'b10; tick();
    slv_tx_first_bit = 1'b0; err_clr = 2'b00;
    chk("R11 set wins over clear", tx_unf_flag, 1);
    err_clr = 2'b10; tick(); err_clr = 2'b00;
    cpu_write(8'h12);
    slv_tx_first_bit = 1'b1; tick(); slv_tx_first_bit = 1'b0;
    chk("R10 no unf when tx holds data", tx_unf_flag, 0);
    irq_en = 4'b0000; tick();
    flush_both();
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b1;
    cpu_wr = 0; cpu_wdata = 0; cpu_rd = 0;
    bus_rx_push = 0; bus_rx_data = 0; bus_tx_pop = 0;
    rx_flush_wr = 0; tx_flush_wr = 0;
    rx_thresh = 0; tx_thresh = 0;
    len_load = 0; len_value = 0;
    slv_rx_first_bit = 0; rx_shift_full = 0; slv_tx_first_bit = 0; master_nacked = 0;
    err_clr = 0; irq_en = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_order();
    t_bounds();
    t_thresh();
    t_flush();
    t_enable();
    t_len();
    t_errors();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule